// File: doc/BRIEF.md
# Ethernet PHY Management Register File

This block is the management-side register file of a 10/100 Ethernet PHY. A host reaches it through a single-cycle command strobe. Each command carries one address word. That word packs a 5-bit PHY address and a 5-bit register address. A command is either a write with a 16-bit data word or a read. The file holds sixteen 16-bit registers. It answers only when the PHY address equals its own. Read data comes back on a registered port one cycle after the command.

The file loads fixed power-on values. It keeps its two identifier registers and its status register read-only. It also follows an external link-up input. When that input changes, the block sets or clears the link bit in the status register and adjusts the link-partner ability register. A write to the control register with its top bit set does not store the value. It returns the whole file to its power-on state, with the link-dependent bits taken from the link input as it is at that moment. A separate link-fail flag reports the inverted link state. The flag is captured on every read command. While scan mode is on, it also follows the link every cycle.

Top module: `phy_mgmt_regfile`

## Requirements
- R1: After reset the registers read as follows: index 0 (control) 0x1000, index 1 (status) 0x7848 with bit 2 set when link is up, index 2 0x2000, index 3 0x5C90, index 4 (advertisement) 0x01E1, index 5 (partner ability) 0x01E1 when link is up and 0x0000 when down, all other indices 0. After reset, rd_data is 0 and link_fail is 0.
- R2: A write of a value with bit 15 set to register index 0 does not store that value. Instead it restores every register to its R1 value, with the link-dependent bits taken from link_up in that same cycle.
- R3: Writes to index 1 (status), index 2 and index 3 leave those registers unchanged.
- R4: A write to index 0 with bit 15 clear, or a write to any of indices 4 to 15, stores the full 16-bit value. A later read returns that value.
- R5: When link_up rises, the status register gets bit 2 set and the partner-ability register gets 0x01E1 ORed in. Both take effect one clock after the change is sampled.
- R6: When link_up falls, status bit 2 is cleared and the partner-ability register is ANDed with 0x01FF.
- R7: The PHY address sits in address bits 4:0 and the register address in bits 12:8. The block answers only at PHY address 1. A read at any other PHY address returns 0xFFFF. A write at any other PHY address changes nothing.
- R8: Register addresses 16 to 31 read as 0x0000 and ignore writes.
- R9: A read command (cmd_valid high, cmd_wr low) updates rd_data on the next clock edge. On that edge it also loads link_fail with the inverse of link_up. rd_data holds its value when no read is issued.
- R10: While scan_en is high, link_fail takes the inverse of link_up on every clock edge.
- R11: With scan_en low and no read command, link_fail keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_wr | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 16 | Register address in bits 12:8, PHY address in bits 4:0 |
| cmd_wdata | input | 16 | Write data |
| scan_en | input | 1 | Continuous link-fail tracking enable |
| link_up | input | 1 | Current link state |
| rd_data | output | 16 | Registered read data |
| link_fail | output | 1 | Captured inverse of link state |

## Verification
The bound checker checks a set of properties on every cycle. These are: the 0xFFFF answer to foreign PHY addresses, zero reads above the register range, and the fixed identifier and status patterns seen through reads. It also checks how link_fail updates on read and scan, and that it holds otherwise, and that rd_data holds between reads. Some behaviours need history that no single-cycle property can follow, so only the bench scenarios can show them. These are: stored values surviving across the register sweep, the partner-ability register merging with link edges after a custom write, and the soft reset wiping earlier writes while sampling the link at that moment.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

   localparam int IDX_CTRL    = 0;
   localparam int IDX_STAT    = 1;
   localparam int IDX_ID_HI   = 2;
   localparam int IDX_ID_LO   = 3;
   localparam int IDX_ADV     = 4;
   localparam int IDX_PARTNER = 5;

   localparam logic [15:0] STAT_LINK_BIT   = 16'h0004;
   localparam logic [15:0] PARTNER_UP_OR   = 16'h01E1;
   localparam logic [15:0] PARTNER_DN_KEEP = 16'h01FF;
   localparam logic [15:0] FOREIGN_READ    = 16'hFFFF;

   typedef enum logic [2:0] {
      KIND_PLAIN,
      KIND_CTRL,
      KIND_CONST,
      KIND_STATUS,
      KIND_PARTNER
   } reg_kind_e;

   function automatic reg_kind_e kind_of(int idx);
      case (idx)
         IDX_CTRL:             return KIND_CTRL;
         IDX_STAT:             return KIND_STATUS;
         IDX_ID_HI, IDX_ID_LO: return KIND_CONST;
         IDX_PARTNER:          return KIND_PARTNER;
         default:              return KIND_PLAIN;
      endcase
   endfunction

   function automatic logic [15:0] power_on_word(int idx);
      case (idx)
         IDX_CTRL:  return 16'h1000;
         IDX_STAT:  return 16'h7848;
         IDX_ID_HI: return 16'h2000;
         IDX_ID_LO: return 16'h5C90;
         IDX_ADV:   return 16'h01E1;
         default:   return 16'h0000;
      endcase
   endfunction

   function automatic logic [15:0] apply_link(int idx, logic [15:0] v, logic up);
      logic [15:0] r;
      r = v;
      if (idx == IDX_STAT) begin
         r = up ? (v | STAT_LINK_BIT) : (v & ~STAT_LINK_BIT);
      end else if (idx == IDX_PARTNER) begin
         r = up ? (v | PARTNER_UP_OR) : (v & PARTNER_DN_KEEP);
      end
      return r;
   endfunction

endpackage

// File: rtl/phy_mgmt_cmd_decode.sv
module phy_mgmt_cmd_decode #(
   parameter int ADDR_W   = 16,
   parameter int REG_AW   = 5,
   parameter int PHY_AW   = 5,
   parameter int REG_LSB  = 8,
   parameter int PHY_LSB  = 0,
   parameter int NUM_REGS = 16,
   parameter int OWN_PHY  = 1
) (
   input  logic              cmd_valid,
   input  logic              cmd_wr,
   input  logic [ADDR_W-1:0] cmd_addr,
   output logic [REG_AW-1:0] reg_idx,
   output logic              phy_hit,
   output logic              in_range,
   output logic              wr_en,
   output logic              rd_cmd
);
   localparam int REG_SPAN = 1 << REG_AW;

   if (REG_LSB + REG_AW > ADDR_W || PHY_LSB + PHY_AW > ADDR_W) begin : g_bad_fields
      $error("address fields exceed address word");
   end
   if (NUM_REGS > REG_SPAN) begin : g_bad_depth
      $error("register count exceeds register address space");
   end

   logic [PHY_AW-1:0] phy_field;

   assign reg_idx   = cmd_addr[REG_LSB +: REG_AW];
   assign phy_field = cmd_addr[PHY_LSB +: PHY_AW];
   assign phy_hit   = (phy_field == PHY_AW'(OWN_PHY));
   assign in_range  = ({1'b0, reg_idx} < (REG_AW+1)'(NUM_REGS));
   assign wr_en     = cmd_valid && cmd_wr && phy_hit && in_range;
   assign rd_cmd    = cmd_valid && !cmd_wr;
endmodule

// File: rtl/phy_mgmt_link_track.sv
module phy_mgmt_link_track (
   input  logic clk,
   input  logic rst_n,
   input  logic link_up,
   input  logic scan_en,
   input  logic rd_cmd,
   output logic link_evt,
   output logic link_fail
);
   logic link_q;

   assign link_evt = (link_up != link_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         link_q    <= link_up;
         link_fail <= 1'b0;
      end else begin
         link_q <= link_up;
         if (rd_cmd || scan_en) begin
            link_fail <= !link_up;
         end
      end
   end
endmodule

// File: rtl/phy_mgmt_reg_array.sv
module phy_mgmt_reg_array
   import phy_mgmt_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int REG_AW   = 5,
   parameter int NUM_REGS = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              link_up,
   input  logic              link_evt,
   output logic [DATA_W-1:0] rd_word
);
   localparam int MIN_REGS = IDX_PARTNER + 1;

   if (DATA_W != 16) begin : g_bad_width
      $error("register width must be 16");
   end
   if (NUM_REGS < MIN_REGS) begin : g_bad_count
      $error("register count too small for fixed registers");
   end

   logic [DATA_W-1:0] word [NUM_REGS];
   logic              soft_rst;
   logic              init;

   assign soft_rst = wr_en && (idx == REG_AW'(IDX_CTRL)) && wr_data[DATA_W-1];
   assign init     = !rst_n || soft_rst;

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      localparam reg_kind_e KIND = kind_of(g);
      localparam logic [DATA_W-1:0] POR = power_on_word(g);
      logic hit;
      assign hit = wr_en && (idx == REG_AW'(g));

      if (KIND == KIND_CONST) begin : g_const
         assign word[g] = POR;
      end else if (KIND == KIND_STATUS) begin : g_status
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk) begin
            if (init) begin
               q <= apply_link(g, POR, link_up);
            end else if (link_evt) begin
               q <= apply_link(g, q, link_up);
            end
         end
         assign word[g] = q;
      end else begin : g_store
         logic [DATA_W-1:0] q;
         logic [DATA_W-1:0] nxt;
         always_comb begin
            nxt = hit ? wr_data : q;
            if (link_evt) begin
               nxt = apply_link(g, nxt, link_up);
            end
         end
         always_ff @(posedge clk) begin
            if (init) begin
               q <= apply_link(g, POR, link_up);
            end else begin
               q <= nxt;
            end
         end
         assign word[g] = q;
      end
   end

   always_comb begin
      rd_word = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (idx == REG_AW'(i)) begin
            rd_word = word[i];
         end
      end
   end
endmodule

// File: rtl/phy_mgmt_regfile.sv
module phy_mgmt_regfile
   import phy_mgmt_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 16,
   parameter int REG_AW   = 5,
   parameter int PHY_AW   = 5,
   parameter int REG_LSB  = 8,
   parameter int PHY_LSB  = 0,
   parameter int NUM_REGS = 16,
   parameter int OWN_PHY  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_wr,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   input  logic              scan_en,
   input  logic              link_up,
   output logic [DATA_W-1:0] rd_data,
   output logic              link_fail
);
   logic [REG_AW-1:0] reg_idx;
   logic              phy_hit;
   logic              in_range;
   logic              wr_en;
   logic              rd_cmd;
   logic              link_evt;
   logic [DATA_W-1:0] rd_word;

   phy_mgmt_cmd_decode #(
      .ADDR_W(ADDR_W), .REG_AW(REG_AW), .PHY_AW(PHY_AW),
      .REG_LSB(REG_LSB), .PHY_LSB(PHY_LSB),
      .NUM_REGS(NUM_REGS), .OWN_PHY(OWN_PHY)
   ) dec_i (
      .cmd_valid(cmd_valid), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr),
      .reg_idx(reg_idx), .phy_hit(phy_hit), .in_range(in_range),
      .wr_en(wr_en), .rd_cmd(rd_cmd)
   );

   phy_mgmt_link_track link_i (
      .clk(clk), .rst_n(rst_n), .link_up(link_up), .scan_en(scan_en),
      .rd_cmd(rd_cmd), .link_evt(link_evt), .link_fail(link_fail)
   );

   phy_mgmt_reg_array #(
      .DATA_W(DATA_W), .REG_AW(REG_AW), .NUM_REGS(NUM_REGS)
   ) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .idx(reg_idx),
      .wr_data(cmd_wdata), .link_up(link_up), .link_evt(link_evt),
      .rd_word(rd_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else if (rd_cmd) begin
         if (!phy_hit) begin
            rd_data <= DATA_W'(FOREIGN_READ);
         end else if (!in_range) begin
            rd_data <= '0;
         end else begin
            rd_data <= rd_word;
         end
      end
   end
endmodule

// File: rtl/phy_mgmt_regfile_chk.sv
module phy_mgmt_regfile_chk #(
   parameter int ADDR_W   = 16,
   parameter int DATA_W   = 16,
   parameter int REG_AW   = 5,
   parameter int PHY_AW   = 5,
   parameter int REG_LSB  = 8,
   parameter int PHY_LSB  = 0,
   parameter int NUM_REGS = 16,
   parameter int OWN_PHY  = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic              cmd_wr,
   input logic [ADDR_W-1:0] cmd_addr,
   input logic              scan_en,
   input logic              link_up,
   input logic [DATA_W-1:0] rd_data,
   input logic              link_fail
);
   logic rd, mine, high;
   logic [REG_AW-1:0] ra;
   assign rd   = cmd_valid && !cmd_wr;
   assign ra   = cmd_addr[REG_LSB +: REG_AW];
   assign mine = cmd_addr[PHY_LSB +: PHY_AW] == PHY_AW'(OWN_PHY);
   assign high = {1'b0, ra} >= (REG_AW+1)'(NUM_REGS);

   // R7
   foreign_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd && !mine |=> rd_data == '1);
   // R8
   high_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd && mine && high |=> rd_data == '0);
   // R3
   id_hi_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd && mine && ra == REG_AW'(2) |=> rd_data == 16'h2000);
   // R3
   status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd && mine && ra == REG_AW'(1) |=> (rd_data & 16'hFFFB) == 16'h7848);
   // R9
   read_latch_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd |=> link_fail == !$past(link_up));
   // R9
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd |=> $stable(rd_data));
   // R10
   scan_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      scan_en |=> link_fail == !$past(link_up));
   // R11
   fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd && !scan_en |=> $stable(link_fail));
endmodule

bind phy_mgmt_regfile phy_mgmt_regfile_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_AW(REG_AW), .PHY_AW(PHY_AW),
   .REG_LSB(REG_LSB), .PHY_LSB(PHY_LSB), .NUM_REGS(NUM_REGS), .OWN_PHY(OWN_PHY)
) chk_i (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_wr(cmd_wr),
   .cmd_addr(cmd_addr), .scan_en(scan_en), .link_up(link_up),
   .rd_data(rd_data), .link_fail(link_fail)
);

// File: tb/phy_mgmt_regfile_tb_top.sv
module phy_mgmt_regfile_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_wr = 1'b0;
   logic [15:0] cmd_addr = '0;
   logic [15:0] cmd_wdata = '0;
   logic        scan_en = 1'b0;
   logic        link_up = 1'b1;
   logic [15:0] rd_data;
   logic        link_fail;

   int checks = 0;
   int errors = 0;
   logic [15:0] exp [16];

   phy_mgmt_regfile dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_wr(cmd_wr),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .scan_en(scan_en),
      .link_up(link_up), .rd_data(rd_data), .link_fail(link_fail)
   );

   always #10 clk = ~clk;

   task automatic chk(string req, logic [15:0] act, logic [15:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, expv);
      end
   endtask

   task automatic do_wr(int phy, int ra, logic [15:0] d);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_wr = 1'b1;
      cmd_addr  = {3'b0, 5'(ra), 3'b0, 5'(phy)};
      cmd_wdata = d;
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0; cmd_wr = 1'b0;
   endtask

   task automatic do_rd(int phy, int ra, output logic [15:0] d);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_wr = 1'b0;
      cmd_addr  = {3'b0, 5'(ra), 3'b0, 5'(phy)};
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      d = rd_data;
   endtask

   function automatic logic [15:0] por(int i, logic up);
      case (i)
         0: return 16'h1000;
         1: return up ? 16'h784C : 16'h7848;
         2: return 16'h2000;
         3: return 16'h5C90;
         4: return 16'h01E1;
         5: return up ? 16'h01E1 : 16'h0000;
         default: return 16'h0000;
      endcase
   endfunction

   initial begin
      #(20ns * 100000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [15:0] v;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      chk("R1 rd_data reset", rd_data, 16'h0000);
      chk("R1 link_fail reset", {15'b0, link_fail}, 16'h0000);

      for (int i = 0; i < 16; i++) begin
         exp[i] = por(i, 1'b1);
         do_rd(1, i, v);
         chk($sformatf("R1 reg %0d", i), v, exp[i]);
      end
      chk("R9 link_fail after read link up", {15'b0, link_fail}, 16'h0000);

      for (int i = 16; i < 32; i++) begin
         do_wr(1, i, 16'hBEEF);
         do_rd(1, i, v);
         chk($sformatf("R8 reg %0d", i), v, 16'h0000);
      end

      for (int i = 1; i < 16; i++) begin
         logic [15:0] d;
         d = 16'hA5A5 ^ 16'(i * 16'h0101);
         do_wr(1, i, d);
         if (i > 3) exp[i] = d;
      end
      for (int i = 1; i < 16; i++) begin
         do_rd(1, i, v);
         if (i <= 3) chk($sformatf("R3 reg %0d", i), v, exp[i]);
         else        chk($sformatf("R4 reg %0d", i), v, exp[i]);
      end
      do_wr(1, 0, 16'h0140);
      exp[0] = 16'h0140;
      do_rd(1, 0, v);
      chk("R4 control store", v, 16'h0140);

      for (int p = 0; p < 32; p++) begin
         if (p != 1) begin
            do_wr(p, 4, 16'hFFFF);
            do_rd(p, 2, v);
            chk($sformatf("R7 foreign phy %0d", p), v, 16'hFFFF);
         end
      end
      do_rd(1, 4, v);
      chk("R7 foreign writes ignored", v, exp[4]);

      @(negedge clk);
      link_up = 1'b0;
      exp[1] = exp[1] & ~16'h0004;
      exp[5] = exp[5] & 16'h01FF;
      @(negedge clk);
      chk("R11 link_fail holds w/o read", {15'b0, link_fail}, 16'h0000);
      do_rd(1, 1, v);
      chk("R6 status link down", v, exp[1]);
      chk("R9 link_fail latched on read", {15'b0, link_fail}, 16'h0001);
      do_rd(1, 5, v);
      chk("R6 partner link down", v, exp[5]);

      @(negedge clk);
      link_up = 1'b1;
      exp[1] = exp[1] | 16'h0004;
      exp[5] = exp[5] | 16'h01E1;
      @(negedge clk);
      chk("R11 link_fail holds after up", {15'b0, link_fail}, 16'h0001);
      do_rd(1, 1, v);
      chk("R5 status link up", v, exp[1]);
      do_rd(1, 5, v);
      chk("R5 partner link up", v, exp[5]);
      chk("R9 link_fail cleared on read", {15'b0, link_fail}, 16'h0000);

      @(negedge clk);
      scan_en = 1'b1;
      link_up = 1'b0;
      @(negedge clk);
      chk("R10 scan tracks down", {15'b0, link_fail}, 16'h0001);
      link_up = 1'b1;
      @(negedge clk);
      chk("R10 scan tracks up", {15'b0, link_fail}, 16'h0000);
      scan_en = 1'b0;
      link_up = 1'b0;
      @(negedge clk);

      do_wr(1, 0, 16'h8123);
      for (int i = 0; i < 16; i++) begin
         do_rd(1, i, v);
         chk($sformatf("R2 soft reset reg %0d", i), v, por(i, 1'b0));
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule